// File: doc/BRIEF.md
# Programmable Binary Timer Divider

This block is a 24-stage binary divider whose count advances once for every high-to-low transition seen on a slow count input. The count input is sampled by the system clock through a two-flop synchroniser. A falling edge becomes a single-cycle enable, so every stage updates in the same system-clock cycle. A 4-bit select code picks one of the upper 16 stages and routes it to the decode output.

A skip control bypasses the lowest eight stages, so the count input drives the ninth stage directly and the sixteen taps give divide lengths of one to sixteen. Other controls are:
- a clear, which takes priority;
- a fill, which forces all stages to one;
- a count hold;
- a split test combination, which breaks the chain into three 8-stage sections that count in parallel.

A digital one-shot can stretch every rising edge of the selected tap into a pulse whose length in system clocks is programmable.

Top module: `prog_divider`

## Requirements
- R1: While `rst_n` is low at a clock edge, all stages, the synchroniser and the one-shot return to zero. After reset, `tap_out` is low.
- R2: Each high-to-low transition of `count_in` advances the divider by exactly one. The new value is visible after the third rising clock edge that follows the transition. Rising transitions do not advance the divider.
- R3: With `skip_low` low, `tap_sel` value s (bit 3 is the most significant) selects stage 9+s. That stage equals bit 8+s of the number of falling edges counted since the last clear.
- R4: With `skip_low` high, the lowest eight stages keep their value and the upper sixteen stages count alone. Tap s then equals bit s of the number of falling edges counted since the last clear.
- R5: While `count_hold` is high, falling edges leave every stage unchanged.
- R6: A high `force_clr` clears all stages on the next clock edge and holds them at zero while it stays high, except in the split combination of R9.
- R7: A high `force_set` with `force_clr` low sets all stages to one on the next clock edge.
- R8: When both `force_set` and `force_clr` are high and `skip_low` is low, clearing wins.
- R9: When `skip_low`, `force_set` and `force_clr` are all high, the chain splits into three 8-stage sections. Each section advances on every falling edge, and no carry passes between sections. After 255 edges all stages are one. Once the three controls drop, one further edge rolls the whole chain to zero.
- R10: With `stretch_en` low, `tap_out` equals the selected stage.
- R11: With `stretch_en` high, a rising edge of the selected stage drives `tap_out` high for exactly `stretch_len` clock cycles, starting one cycle after the stage changes. A length of zero gives no pulse.
- R12: A new rising edge of the selected stage during a pulse restarts the full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_in | input | 1 | Asynchronous count input; advances on falling transitions |
| force_set | input | 1 | Forces all stages to one |
| force_clr | input | 1 | Clears all stages; has priority |
| skip_low | input | 1 | Bypasses the lowest eight stages |
| count_hold | input | 1 | Freezes the divider |
| tap_sel | input | 4 | Selects one of the sixteen upper stages |
| stretch_en | input | 1 | Routes the tap through the one-shot |
| stretch_len | input | 16 | One-shot pulse length in clock cycles |
| tap_out | output | 1 | Selected stage, direct or stretched |

## Verification
The divider changes after the third rising clock edge that follows a drop of `count_in`: two edges fill the synchroniser and the third applies the step. The bench waits three clock cycles after each drop and only then compares the tap, and one directed test samples the cycles on both sides of that edge. Force and clear controls take effect after one edge, so the bench checks them one cycle after it drives them. A one-shot pulse starts one cycle after the tap rises, so the bench counts high cycles over a fixed window and compares the total with the programmed length.

// File: rtl/prog_divider_pkg.sv
// Shared defaults and types for the programmable divider.
// Assumes the stage count is a multiple of the section size.
package prog_divider_pkg;
    localparam int DEF_STAGES = 24;
    localparam int DEF_SECT   = 8;
    localparam int DEF_SEL_W  = 4;
    localparam int DEF_LEN_W  = 16;

    typedef enum logic [1:0] {
        MODE_SERIAL = 2'd0,
        MODE_SKIP   = 2'd1,
        MODE_SPLIT  = 2'd2
    } chain_mode_e;
endpackage

// File: rtl/fall_detect.sv
// Synchronises an asynchronous count input with two flops and emits a
// one-cycle strobe on each high-to-low transition.
// Assumes the input stays at each level for at least two system clocks.
module fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic meta_q, sync_q, last_q;

    // Two-flop synchroniser plus one delay stage used to compare levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            last_q <= 1'b0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign fall = last_q & ~sync_q;

    // R2: a recognised drop lasts exactly one cycle.
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/stage_chain.sv
// Holds the divider stages. The chain counts as one serial counter, as an
// upper counter with the low section frozen, or as independent sections.
// Assumes STAGES is a multiple of SECT.
module stage_chain
    import prog_divider_pkg::*;
#(
    parameter int STAGES = DEF_STAGES,
    parameter int SECT   = DEF_SECT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  chain_mode_e       mode,
    input  logic              step,
    input  logic              hold,
    input  logic              force_clr,
    input  logic              force_set,
    output logic [STAGES-1:0] q
);
    localparam int NSECT = STAGES / SECT;
    localparam int UPPER = STAGES - SECT;

    logic [STAGES-1:0] serial_nx;
    logic [STAGES-1:0] skip_nx;
    logic [STAGES-1:0] split_nx;

    // Next value when the chain runs as one counter.
    always_comb serial_nx = q + STAGES'(1);

    // Next value when the low section is bypassed.
    always_comb skip_nx = {q[STAGES-1:SECT] + UPPER'(1), q[SECT-1:0]};

    // Next value of each independent section in split mode.
    generate
        for (genvar g = 0; g < NSECT; g++) begin : g_sect
            assign split_nx[g*SECT +: SECT] = q[g*SECT +: SECT] + SECT'(1);
        end
    endgenerate

    // Stage register: split counting first, then clear, fill, count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (mode == MODE_SPLIT) begin
            if (step && !hold) q <= split_nx;
        end else if (force_clr) begin
            q <= '0;
        end else if (force_set) begin
            q <= '1;
        end else if (step && !hold) begin
            q <= (mode == MODE_SKIP) ? skip_nx : serial_nx;
        end
    end

    // R6 and R8: clearing wins outside split mode.
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_SPLIT && force_clr) |=> (q == '0));
    // R7: fill forces all ones.
    a_r7_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_SPLIT && !force_clr && force_set) |=> (&q));
    // R5: holding freezes the stages.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && (mode == MODE_SPLIT || (!force_clr && !force_set))) |=> $stable(q));
    // R2: one step per strobe in serial mode.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SERIAL && !force_clr && !force_set && step && !hold)
        |=> (q == $past(q) + STAGES'(1)));
    // R4: the bypassed section never moves.
    a_r4_low_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_SKIP && !force_clr && !force_set)
        |=> (q[SECT-1:0] == $past(q[SECT-1:0])));
endmodule

// File: rtl/tap_mux.sv
// Selects one of the upper stages by a binary code.
// Assumes the number of upper stages equals 2**SEL_W.
module tap_mux #(
    parameter int SEL_W = 4
) (
    input  logic [(1<<SEL_W)-1:0] upper,
    input  logic [SEL_W-1:0]      sel,
    output logic                  tap
);
    // Plain indexed pick of the chosen stage.
    always_comb tap = upper[sel];
endmodule

// File: rtl/pulse_stretch.sv
// Passes the tap straight through, or turns each rising edge of it into
// a pulse lasting a programmed number of clock cycles. A new edge during
// a pulse restarts the count. Disabling clears any pulse in progress.
module pulse_stretch #(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [LEN_W-1:0] width,
    input  logic             tap,
    output logic             dout
);
    logic             tap_d;
    logic [LEN_W-1:0] remain;
    logic             rise;

    assign rise = tap & ~tap_d;

    // Delayed tap used to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) tap_d <= 1'b0;
        else        tap_d <= tap;
    end

    // Pulse length counter: load on an edge, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)              remain <= '0;
        else if (!enable)        remain <= '0;
        else if (rise)           remain <= width;
        else if (remain != '0)   remain <= remain - LEN_W'(1);
    end

    assign dout = enable ? (remain != '0) : tap;

    // R11 and R12: every edge loads the full length.
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rise) |=> (remain == $past(width)));
    // R11: the length counts down by one per cycle.
    a_r11_count: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !rise && remain != '0) |=> (remain == $past(remain) - LEN_W'(1)));
endmodule

// File: rtl/prog_divider.sv
// Top of the programmable divider. Decodes the chain mode from the
// control inputs and wires together the edge detector, the stage chain,
// the tap selector and the one-shot.
// Assumes all controls except count_in are synchronous to clk.
module prog_divider
    import prog_divider_pkg::*;
#(
    parameter int STAGES = DEF_STAGES,
    parameter int SECT   = DEF_SECT,
    parameter int SEL_W  = DEF_SEL_W,
    parameter int LEN_W  = DEF_LEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_in,
    input  logic             force_set,
    input  logic             force_clr,
    input  logic             skip_low,
    input  logic             count_hold,
    input  logic [SEL_W-1:0] tap_sel,
    input  logic             stretch_en,
    input  logic [LEN_W-1:0] stretch_len,
    output logic             tap_out
);
    chain_mode_e       mode;
    logic              step;
    logic [STAGES-1:0] stages;
    logic              tap;

    // Mode decode: the three-way combination selects split counting.
    always_comb begin
        if (skip_low && force_set && force_clr) mode = MODE_SPLIT;
        else if (skip_low)                      mode = MODE_SKIP;
        else                                    mode = MODE_SERIAL;
    end

    fall_detect u_fall (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (count_in),
        .fall (step)
    );

    stage_chain #(.STAGES(STAGES), .SECT(SECT)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .step     (step),
        .hold     (count_hold),
        .force_clr(force_clr),
        .force_set(force_set),
        .q        (stages)
    );

    tap_mux #(.SEL_W(SEL_W)) u_mux (
        .upper(stages[STAGES-1:SECT]),
        .sel  (tap_sel),
        .tap  (tap)
    );

    pulse_stretch #(.LEN_W(LEN_W)) u_stretch (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(stretch_en),
        .width (stretch_len),
        .tap   (tap),
        .dout  (tap_out)
    );

    // R1: output is low right after reset.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !tap_out);
endmodule

// File: tb/prog_divider_bench.sv
module prog_divider_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        count_in = 1'b1;
    logic        force_set = 1'b0;
    logic        force_clr = 1'b0;
    logic        skip_low = 1'b0;
    logic        count_hold = 1'b0;
    logic [3:0]  tap_sel = 4'd0;
    logic        stretch_en = 1'b0;
    logic [15:0] stretch_len = 16'd0;
    logic        tap_out;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    prog_divider u_prog_divider (
        .clk(clk), .rst_n(rst_n), .count_in(count_in),
        .force_set(force_set), .force_clr(force_clr), .skip_low(skip_low),
        .count_hold(count_hold), .tap_sel(tap_sel), .stretch_en(stretch_en),
        .stretch_len(stretch_len), .tap_out(tap_out)
    );

    // Vector: {skip, sel[3:0], edges[11:0], expected tap}
    localparam int NVEC = 10;
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 4'd0,  12'd255,  1'b0},
        {1'b0, 4'd0,  12'd256,  1'b1},
        {1'b0, 4'd1,  12'd512,  1'b1},
        {1'b0, 4'd1,  12'd256,  1'b0},
        {1'b1, 4'd0,  12'd1,    1'b1},
        {1'b1, 4'd0,  12'd2,    1'b0},
        {1'b1, 4'd3,  12'd8,    1'b1},
        {1'b1, 4'd3,  12'd7,    1'b0},
        {1'b1, 4'd4,  12'd24,   1'b1},
        {1'b0, 4'd2,  12'd1024, 1'b1}
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: tap_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic fall_edge();
        count_in = 1'b0;
        repeat (3) tick();
        count_in = 1'b1;
        repeat (3) tick();
    endtask

    task automatic clear_chain();
        force_clr = 1'b1;
        tick();
        force_clr = 1'b0;
    endtask

    // Drives nfalls falling edges six cycles apart and counts high samples.
    task automatic pulse_window(input int nfalls, input int window, output int highs);
        highs = 0;
        for (int i = 0; i < window; i++) begin
            count_in = (i < nfalls * 6) ? ((i % 6) >= 3) : 1'b1;
            tick();
            if (tap_out) highs++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: run did not finish, got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int highs;
        repeat (4) tick();
        // R1: reset state
        chk("R1 reset tap low", tap_out, 1'b0);
        rst_n = 1'b1;
        tick();
        tap_sel = 4'd15;
        tick();
        chk("R1 top stage zero after reset", tap_out, 1'b0);

        // R3 R4 R10: vector table, tap passed straight through
        for (int v = 0; v < NVEC; v++) begin
            clear_chain();
            skip_low = VEC[v][17];
            tap_sel  = VEC[v][16:13];
            for (int e = 0; e < int'(VEC[v][12:1]); e++) fall_edge();
            tick();
            chk(VEC[v][17] ? "R4 skip tap" : "R3 serial tap", tap_out, VEC[v][0]);
        end
        skip_low = 1'b0;

        // R2: latency of three rising edges, and rising edges do not count
        clear_chain();
        skip_low = 1'b1;
        tap_sel = 4'd0;
        tick();
        count_in = 1'b0;
        tick(); tick();
        chk("R2 not yet stepped", tap_out, 1'b0);
        tick();
        chk("R2 stepped on third edge", tap_out, 1'b1);
        repeat (3) tick();
        count_in = 1'b1;
        repeat (5) tick();
        chk("R2 rising edge ignored", tap_out, 1'b1);

        // R4: low section frozen while bypassed
        force_set = 1'b1; skip_low = 1'b0;
        tick();
        force_set = 1'b0; skip_low = 1'b1;
        fall_edge();
        tap_sel = 4'd0;
        tick();
        chk("R4 upper wrapped", tap_out, 1'b0);
        skip_low = 1'b0;
        fall_edge();
        chk("R4 low section kept ones, carry reached stage 9", tap_out, 1'b1);

        // R5: hold
        clear_chain();
        skip_low = 1'b1;
        count_hold = 1'b1;
        repeat (3) fall_edge();
        tap_sel = 4'd0;
        tick();
        chk("R5 held stage 9", tap_out, 1'b0);
        tap_sel = 4'd1;
        tick();
        chk("R5 held stage 10", tap_out, 1'b0);
        count_hold = 1'b0;
        fall_edge();
        tap_sel = 4'd0;
        tick();
        chk("R5 counts after release", tap_out, 1'b1);

        // R7: fill
        skip_low = 1'b0;
        force_set = 1'b1;
        tap_sel = 4'd15;
        tick();
        force_set = 1'b0;
        tick();
        chk("R7 fill top stage", tap_out, 1'b1);
        // R8: clear wins over fill
        force_set = 1'b1; force_clr = 1'b1;
        tick();
        chk("R8 clear priority", tap_out, 1'b0);
        // R6: clear holds while high
        force_set = 1'b0;
        tap_sel = 4'd0;
        fall_edge(); fall_edge();
        chk("R6 held at zero", tap_out, 1'b0);
        force_clr = 1'b0;

        // R9: split test mode
        force_clr = 1'b1;
        tick();
        skip_low = 1'b1; force_set = 1'b1;
        fall_edge();
        tap_sel = 4'd0; tick();
        chk("R9 section 2 bit0", tap_out, 1'b1);
        tap_sel = 4'd8; tick();
        chk("R9 section 3 bit0", tap_out, 1'b1);
        tap_sel = 4'd1; tick();
        chk("R9 no cross carry", tap_out, 1'b0);
        for (int e = 1; e < 255; e++) fall_edge();
        for (int s = 0; s < 16; s++) begin
            tap_sel = 4'(s);
            tick();
            chk("R9 all ones after 255 edges", tap_out, 1'b1);
        end
        skip_low = 1'b0; force_set = 1'b0; force_clr = 1'b0;
        fall_edge();
        tap_sel = 4'd15; tick();
        chk("R9 top stage rolled to zero", tap_out, 1'b0);
        tap_sel = 4'd0; tick();
        chk("R9 stage 9 rolled to zero", tap_out, 1'b0);

        // R11: one-shot length
        clear_chain();
        skip_low = 1'b1; tap_sel = 4'd0;
        stretch_en = 1'b1; stretch_len = 16'd5;
        tick();
        pulse_window(1, 30, highs);
        chk_int("R11 pulse length 5", highs, 5);
        clear_chain();
        stretch_len = 16'd0;
        tick();
        pulse_window(1, 30, highs);
        chk_int("R11 zero length no pulse", highs, 0);
        // R12: restart during a pulse
        clear_chain();
        stretch_len = 16'd20;
        tick();
        pulse_window(3, 80, highs);
        chk_int("R12 retrigger extends pulse", highs, 32);
        stretch_en = 1'b0;
        tick();
        chk("R10 direct tap after disable", tap_out, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule